// File: doc/BRIEF.md
# Passive Serial Bitstream Loader

This block programs a target FPGA over its passive serial configuration pins. A one-cycle start request, together with a chunk count, begins a load. The loader drives the active-low configuration request low for a fixed number of clocks and then releases it. It waits until the target's status line changes level, which is the target's handshake. It then pulls bitstream bytes from a byte-wide valid/ready input, in whole chunks of a parameterised size, and shifts each byte out least significant bit first on a serial data pin with a generated serial clock.

Once the last byte has gone out, the loader issues a parameterised number of extra serial clocks and then checks the target's configuration-done input. If that input is high, the loader releases the target's active-low reset. In every finishing case it latches the target's done, init-done and status levels on report outputs. If the handshake never arrives within the timeout, or if configuration-done is low at the check, the load ends with an error flag and the target stays in reset.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset, cfgReqN is 1, tgtResetN is 0, serClk is 0, and inReady, busy, done and error are all 0.
- R2: A start pulse seen while idle drives cfgReqN low for exactly PULSE_CYCLES clock cycles, after which it returns high.
- R3: While cfgReqN is low, and until the synchronised tgtStatusN level differs from its level at the moment cfgReqN rose, serClk stays low and no byte is accepted (inReady is 0).
- R4: Each accepted byte is sent on serData bit 0 first, through bit 7 last, with one serClk rising edge per bit.
- R5: serData changes only on the clock edge where serClk is low or falls, so it is stable at every serClk rising edge.
- R6: A load accepts exactly chunkCount × CHUNK_BYTES bytes (a byte is taken on a cycle with inValid and inReady both 1), and further offered bytes are not accepted.
- R7: After the last data bit, exactly TRAIL_CLOCKS further serClk rising edges are issued with serData at 0, and only then is tgtCfgDone judged.
- R8: tgtResetN stays 0 while busy is 1, and goes to 1 at the end of a load only if the synchronised tgtCfgDone is 1 at the check.
- R9: When a load finishes, whether it succeeds or fails, rptCfgDone, rptInitDone and rptStatusN take the synchronised levels of tgtCfgDone, tgtInitDone and tgtStatusN, and done becomes 1 while busy becomes 0.
- R10: If the status change does not arrive within STATUS_TIMEOUT cycles of cfgReqN rising, the load ends with error at 1, no serial clock and no byte taken.
- R11: If tgtCfgDone is low at the check, error becomes 1 and tgtResetN stays 0.
- R12: A status change that is first seen on the same cycle as the timeout expiry wins, so the load continues with no error.
- R13: A start pulse while busy is 1 is ignored: cfgReqN is not pulsed again and the load in progress completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| chunkCount | input | CHUNK_W | Number of chunks to send, sampled at start |
| inValid | input | 1 | Byte source has a byte |
| inData | input | 8 | Bitstream byte |
| inReady | output | 1 | Loader takes the byte this cycle |
| cfgReqN | output | 1 | Active-low configuration request to target |
| tgtStatusN | input | 1 | Target status line (asynchronous) |
| serClk | output | 1 | Serial configuration clock |
| serData | output | 1 | Serial configuration data |
| tgtCfgDone | input | 1 | Target configuration-done (asynchronous) |
| tgtInitDone | input | 1 | Target init-done (asynchronous) |
| tgtResetN | output | 1 | Active-low reset to target logic |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load finished |
| error | output | 1 | Last load failed |
| rptCfgDone | output | 1 | Latched config-done level at finish |
| rptInitDone | output | 1 | Latched init-done level at finish |
| rptStatusN | output | 1 | Latched status level at finish |

## Verification
The status handshake and the timeout expiry can fall in the same cycle, and the control then has to choose between streaming and aborting. The bench provokes this by raising tgtStatusN a swept number of cycles after cfgReqN rises, so that the synchronised change lands just before, exactly on, and just after the expiry cycle. It judges each run by the error flag and by whether the load reaches a clean finish. From the synchroniser depth and the timer load, the bench computes the last delay that must still succeed, and a change seen on the expiry cycle must succeed.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_STREAM,
    ST_TRAIL,
    ST_CHECK
  } ld_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadJob;   // capture chunk count
    logic pulseArm;  // load timer with request pulse length
    logic waitArm;   // load timer with handshake timeout, record status level
    logic streamEn;  // allow byte intake
    logic trailArm;  // start trailing clocks
    logic report;    // latch target levels on report outputs
  } ld_strobe_t;

endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/ps_cfg_datapath.sv
module ps_cfg_datapath
  import ps_cfg_pkg::*;
#(
  parameter int PULSE_CYCLES   = 1000,
  parameter int STATUS_TIMEOUT = 5000,
  parameter int TRAIL_CLOCKS   = 8,
  parameter int CHUNK_BYTES    = 256,
  parameter int CHUNK_W        = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ld_strobe_t         st,
  input  logic [CHUNK_W-1:0] chunkCount,
  input  logic               inValid,
  input  logic [7:0]         inData,
  output logic               inReady,
  input  logic               tgtStatusN,
  input  logic               tgtCfgDone,
  input  logic               tgtInitDone,
  output logic               serClk,
  output logic               serData,
  output logic               tmrZero,
  output logic               statChanged,
  output logic               bytesDone,
  output logic               clkIdle,
  output logic               cfgDoneS,
  output logic               rptCfgDone,
  output logic               rptInitDone,
  output logic               rptStatusN
);
  localparam int TMAX  = (PULSE_CYCLES > STATUS_TIMEOUT) ? PULSE_CYCLES : STATUS_TIMEOUT;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int CMAX  = (TRAIL_CLOCKS > 8) ? TRAIL_CLOCKS : 8;
  localparam int CW    = $clog2(CMAX + 1);
  localparam int BLOG  = $clog2(CHUNK_BYTES);
  localparam int BW    = CHUNK_W + BLOG;

  // synchronised target levels: {status, init-done, config-done}
  logic [2:0] tgtRaw;
  logic [2:0] tgtSync;
  assign tgtRaw = {tgtStatusN, tgtInitDone, tgtCfgDone};

  ps_cfg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .d    (tgtRaw),
    .q    (tgtSync)
  );

  logic statusS;
  assign statusS  = tgtSync[2];
  assign cfgDoneS = tgtSync[0];

  // shared timer for request pulse and handshake timeout
  logic [TW-1:0] tmr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tmr <= '0;
    else if (st.pulseArm)   tmr <= TW'(PULSE_CYCLES - 1);
    else if (st.waitArm)    tmr <= TW'(STATUS_TIMEOUT - 1);
    else if (tmr != '0)     tmr <= tmr - 1'b1;
  end
  assign tmrZero = (tmr == '0);

  // status level recorded when the request is released
  logic statRef;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            statRef <= 1'b1;
    else if (st.waitArm)  statRef <= statusS;
  end
  assign statChanged = (statusS != statRef);

  // remaining byte count
  logic [BW-1:0] byteLeft;
  logic          take;
  assign bytesDone = (byteLeft == '0);

  // serial shifter
  logic [7:0]    shReg;
  logic [CW-1:0] clkLeft;
  logic          clkReg;
  logic          dataReg;
  assign clkIdle = (clkLeft == '0);
  assign inReady = st.streamEn && clkIdle && !bytesDone;
  assign take    = inReady && inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            byteLeft <= '0;
    else if (st.loadJob)  byteLeft <= BW'(chunkCount) << BLOG;
    else if (take)        byteLeft <= byteLeft - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      clkLeft <= '0;
      clkReg  <= 1'b0;
      dataReg <= 1'b0;
    end else if (take) begin
      shReg   <= inData;
      clkLeft <= CW'(8);
      clkReg  <= 1'b0;
      dataReg <= inData[0];
    end else if (st.trailArm) begin
      shReg   <= '0;
      clkLeft <= CW'(TRAIL_CLOCKS);
      clkReg  <= 1'b0;
      dataReg <= 1'b0;
    end else if (clkLeft != '0) begin
      if (!clkReg) begin
        clkReg <= 1'b1;
      end else begin
        clkReg  <= 1'b0;
        clkLeft <= clkLeft - 1'b1;
        shReg   <= {1'b0, shReg[7:1]};
        dataReg <= shReg[1];
      end
    end
  end

  assign serClk  = clkReg;
  assign serData = dataReg;

  // report latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rptCfgDone  <= 1'b0;
      rptInitDone <= 1'b0;
      rptStatusN  <= 1'b0;
    end else if (st.report) begin
      rptCfgDone  <= tgtSync[0];
      rptInitDone <= tgtSync[1];
      rptStatusN  <= tgtSync[2];
    end
  end
endmodule

// File: rtl/ps_cfg_ctrl.sv
module ps_cfg_ctrl
  import ps_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       tmrZero,
  input  logic       statChanged,
  input  logic       bytesDone,
  input  logic       clkIdle,
  input  logic       cfgDoneS,
  output ld_strobe_t st,
  output logic       cfgReqN,
  output logic       tgtResetN,
  output logic       busy,
  output logic       done,
  output logic       error
);
  ld_state_t state;
  ld_state_t nxt;
  logic      failNow;

  always_comb begin
    st      = '0;
    nxt     = state;
    failNow = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          st.loadJob  = 1'b1;
          st.pulseArm = 1'b1;
          nxt         = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (tmrZero) begin
          st.waitArm = 1'b1;
          nxt        = ST_WAIT;
        end
      end
      ST_WAIT: begin
        // a status change has priority over the expiring timeout
        if (statChanged) begin
          nxt = ST_STREAM;
        end else if (tmrZero) begin
          st.report = 1'b1;
          failNow   = 1'b1;
          nxt       = ST_IDLE;
        end
      end
      ST_STREAM: begin
        st.streamEn = 1'b1;
        if (bytesDone && clkIdle) begin
          st.trailArm = 1'b1;
          nxt         = ST_TRAIL;
        end
      end
      ST_TRAIL: begin
        if (clkIdle) nxt = ST_CHECK;
      end
      ST_CHECK: begin
        st.report = 1'b1;
        failNow   = !cfgDoneS;
        nxt       = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cfgReqN   <= 1'b1;
      tgtResetN <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      state <= nxt;
      if (st.pulseArm) begin
        cfgReqN   <= 1'b0;
        tgtResetN <= 1'b0;
        done      <= 1'b0;
        error     <= 1'b0;
      end
      if (st.waitArm) cfgReqN <= 1'b1;
      if (st.report) begin
        done  <= 1'b1;
        error <= failNow;
        if (state == ST_CHECK && cfgDoneS) tgtResetN <= 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
  import ps_cfg_pkg::*;
#(
  parameter int PULSE_CYCLES   = 1000,
  parameter int STATUS_TIMEOUT = 5000,
  parameter int TRAIL_CLOCKS   = 8,
  parameter int CHUNK_BYTES    = 256,  // power of two
  parameter int CHUNK_W        = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CHUNK_W-1:0] chunkCount,
  input  logic               inValid,
  input  logic [7:0]         inData,
  output logic               inReady,
  output logic               cfgReqN,
  input  logic               tgtStatusN,
  output logic               serClk,
  output logic               serData,
  input  logic               tgtCfgDone,
  input  logic               tgtInitDone,
  output logic               tgtResetN,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic               rptCfgDone,
  output logic               rptInitDone,
  output logic               rptStatusN
);
  ld_strobe_t st;
  logic tmrZero, statChanged, bytesDone, clkIdle, cfgDoneS;

  ps_cfg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .tmrZero     (tmrZero),
    .statChanged (statChanged),
    .bytesDone   (bytesDone),
    .clkIdle     (clkIdle),
    .cfgDoneS    (cfgDoneS),
    .st          (st),
    .cfgReqN     (cfgReqN),
    .tgtResetN   (tgtResetN),
    .busy        (busy),
    .done        (done),
    .error       (error)
  );

  ps_cfg_datapath #(
    .PULSE_CYCLES   (PULSE_CYCLES),
    .STATUS_TIMEOUT (STATUS_TIMEOUT),
    .TRAIL_CLOCKS   (TRAIL_CLOCKS),
    .CHUNK_BYTES    (CHUNK_BYTES),
    .CHUNK_W        (CHUNK_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .chunkCount  (chunkCount),
    .inValid     (inValid),
    .inData      (inData),
    .inReady     (inReady),
    .tgtStatusN  (tgtStatusN),
    .tgtCfgDone  (tgtCfgDone),
    .tgtInitDone (tgtInitDone),
    .serClk      (serClk),
    .serData     (serData),
    .tmrZero     (tmrZero),
    .statChanged (statChanged),
    .bytesDone   (bytesDone),
    .clkIdle     (clkIdle),
    .cfgDoneS    (cfgDoneS),
    .rptCfgDone  (rptCfgDone),
    .rptInitDone (rptInitDone),
    .rptStatusN  (rptStatusN)
  );
endmodule

// File: rtl/ps_cfg_loader_chk.sv
module ps_cfg_loader_chk (
  input logic clk,
  input logic rstN,
  input logic cfgReqN,
  input logic serClk,
  input logic serData,
  input logic inReady,
  input logic busy,
  input logic done,
  input logic error,
  input logic tgtResetN
);
  // R5
  ser_data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serClk) |-> $stable(serData));

  // R3
  req_low_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReqN |-> (!serClk && !inReady));

  // R8
  reset_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !tgtResetN);

  // R11
  error_keeps_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !tgtResetN);

  // R6
  ready_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> busy);

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(busy));
endmodule

bind ps_cfg_loader ps_cfg_loader_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgReqN   (cfgReqN),
  .serClk    (serClk),
  .serData   (serData),
  .inReady   (inReady),
  .busy      (busy),
  .done      (done),
  .error     (error),
  .tgtResetN (tgtResetN)
);

// File: tb/ps_cfg_loader_tb.sv
`timescale 1ns/1ps
module ps_cfg_loader_tb;
  localparam int PULSE = 20;
  localparam int TMO   = 40;
  localparam int TRAIL = 8;
  localparam int CB    = 256;
  localparam int CW    = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] chunkCount = '0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, cfgReqN, serClk, serData, tgtResetN, busy, done, error;
  logic rptCfgDone, rptInitDone, rptStatusN;
  logic tgtStatusN = 1'b1;
  logic tgtCfgDone = 1'b0;
  logic tgtInitDone = 1'b0;

  ps_cfg_loader #(
    .PULSE_CYCLES(PULSE), .STATUS_TIMEOUT(TMO), .TRAIL_CLOCKS(TRAIL),
    .CHUNK_BYTES(CB), .CHUNK_W(CW)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .chunkCount(chunkCount),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .cfgReqN(cfgReqN), .tgtStatusN(tgtStatusN), .serClk(serClk), .serData(serData),
    .tgtCfgDone(tgtCfgDone), .tgtInitDone(tgtInitDone), .tgtResetN(tgtResetN),
    .busy(busy), .done(done), .error(error),
    .rptCfgDone(rptCfgDone), .rptInitDone(rptInitDone), .rptStatusN(rptStatusN)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] patByte(input int i, input int s);
    return 8'(((i * 29) + (s * 7) + (i >> 3)) ^ 8'h5A);
  endfunction

  // target-side monitor: samples serData on serClk rising edges
  int riseCnt = 0;
  int capN = 0;
  int bitIdx = 0;
  int cfgLowCnt = 0;
  logic prevClk = 1'b0;
  logic [7:0] bitBuf = '0;
  logic [7:0] capBytes [0:1023];

  always @(negedge clk) begin
    if (serClk && !prevClk) begin
      riseCnt++;
      bitBuf = {serData, bitBuf[7:1]};
      bitIdx++;
      if (bitIdx == 8) begin
        if (capN < 1024) capBytes[capN] = bitBuf;
        capN++;
        bitIdx = 0;
      end
    end
    prevClk = serClk;
    if (rstN && !cfgReqN) cfgLowCnt++;
  end

  // byte source
  int srcIdx = 0;
  int accCnt = 0;
  int srcMax = 0;
  int seed = 0;
  bit gapMode = 1'b0;
  bit gapTick = 1'b0;
  bit hsPending = 1'b0;

  always @(negedge clk) begin
    if (hsPending) begin
      srcIdx++;
      accCnt++;
    end
    gapTick = ~gapTick;
    inValid = (srcIdx < srcMax) && !(gapMode && gapTick);
    inData  = patByte(srcIdx, seed);
    hsPending = inValid && inReady;
  end

  task automatic clear_counts();
    @(posedge clk);
    riseCnt = 0; capN = 0; bitIdx = 0; cfgLowCnt = 0;
    srcIdx = 0; accCnt = 0; hsPending = 1'b0; srcMax = 0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic test_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(cfgReqN == 1'b1, "R1 cfgReqN", cfgReqN, 1);
    chk(tgtResetN == 1'b0, "R1 tgtResetN", tgtResetN, 0);
    chk(serClk == 1'b0, "R1 serClk", serClk, 0);
    chk({inReady, busy, done, error} == 4'b0, "R1 ready/busy/done/error",
        {inReady, busy, done, error}, 0);
  endtask

  // full load with a target model; several input patterns
  task automatic run_load(input int chunks, input bit gap, input bit initVal,
                          input bit cfgVal, input bit poke);
    int nBytes;
    int mism;
    int firstAct;
    int firstExp;
    bit poked;
    clear_counts();
    nBytes = chunks * CB;
    tgtCfgDone = cfgVal;
    tgtInitDone = initVal;
    tgtStatusN = 1'b1;
    chunkCount = CW'(chunks);
    seed = chunks * 5 + int'(gap) * 3 + int'(poke);
    gapMode = gap;
    srcMax = nBytes + 4;
    pulse_start();
    while (cfgReqN) @(negedge clk);
    tgtStatusN = 1'b0;
    while (!cfgReqN) @(negedge clk);
    repeat (3) @(negedge clk);
    // R3: nothing moves before the handshake
    chk(riseCnt == 0, "R3 serClk edges before status change", riseCnt, 0);
    chk(accCnt == 0, "R3 bytes taken before status change", accCnt, 0);
    chk(tgtResetN == 1'b0, "R8 target reset held during load", tgtResetN, 0);
    tgtStatusN = 1'b1;
    poked = 1'b0;
    while (!done) begin
      @(negedge clk);
      if (poke && !poked && accCnt == 10) begin
        start = 1'b1;
        poked = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    srcMax = 0;
    // R2 request pulse length; R13 no second pulse when poked while busy
    chk(cfgLowCnt == PULSE, poke ? "R13 start while busy ignored" : "R2 request pulse length",
        cfgLowCnt, PULSE);
    chk(accCnt == nBytes, "R6 bytes accepted", accCnt, nBytes);
    mism = 0; firstAct = 0; firstExp = 0;
    for (int i = 0; i < nBytes; i++) begin
      if (capBytes[i] !== patByte(i, seed)) begin
        if (mism == 0) begin
          firstAct = int'(capBytes[i]);
          firstExp = int'(patByte(i, seed));
        end
        mism++;
      end
    end
    chk(mism == 0, "R4 LSB-first bytes (first mismatch)", firstAct, firstExp);
    chk(riseCnt == nBytes * 8 + TRAIL, "R7 serial clock count incl. trailer",
        riseCnt, nBytes * 8 + TRAIL);
    chk(tgtResetN == cfgVal, "R8 target reset release", tgtResetN, cfgVal);
    chk(error == !cfgVal, "R11 error vs config-done", error, !cfgVal);
    chk(busy == 1'b0 && done == 1'b1, "R9 done/busy at finish", {busy, done}, 1);
    chk(rptCfgDone == cfgVal, "R9 rptCfgDone", rptCfgDone, cfgVal);
    chk(rptInitDone == initVal, "R9 rptInitDone", rptInitDone, initVal);
    chk(rptStatusN == 1'b1, "R9 rptStatusN", rptStatusN, 1);
  endtask

  task automatic test_timeout();
    clear_counts();
    chunkCount = CW'(1);
    tgtCfgDone = 1'b1;
    srcMax = 8;
    pulse_start();
    while (cfgReqN) @(negedge clk);
    tgtStatusN = 1'b0;
    while (!done) @(negedge clk);
    chk(error == 1'b1, "R10 timeout error", error, 1);
    chk(riseCnt == 0, "R10 no serial clock on timeout", riseCnt, 0);
    chk(accCnt == 0, "R10 no byte taken on timeout", accCnt, 0);
    chk(tgtResetN == 1'b0, "R10 target stays in reset", tgtResetN, 0);
    chk(rptStatusN == 1'b0, "R9 rptStatusN at abort", rptStatusN, 0);
    srcMax = 0;
    tgtStatusN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // status change swept around the timeout expiry
  task automatic test_tie_sweep();
    for (int d = TMO - 5; d <= TMO - 1; d++) begin
      bit expErr;
      clear_counts();
      chunkCount = '0;
      tgtCfgDone = 1'b1;
      tgtStatusN = 1'b1;
      pulse_start();
      while (cfgReqN) @(negedge clk);
      tgtStatusN = 1'b0;
      while (!cfgReqN) @(negedge clk);
      repeat (d) @(negedge clk);
      tgtStatusN = 1'b1;
      while (!done) @(negedge clk);
      // change is seen d+3 edges after release; expiry is at TMO edges
      expErr = (d + 3 > TMO);
      chk(error == expErr, (d + 3 == TMO) ? "R12 change on expiry cycle wins"
                                          : "R10 timeout sweep", error, expErr);
      chk(tgtResetN == !expErr, "R12 reset release in sweep", tgtResetN, !expErr);
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected<%0d", 150000, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    test_reset();
    run_load(2, 1'b0, 1'b1, 1'b1, 1'b0);
    run_load(1, 1'b1, 1'b0, 1'b1, 1'b0);
    run_load(1, 1'b0, 1'b1, 1'b1, 1'b1);
    run_load(1, 1'b1, 1'b1, 1'b0, 1'b0);
    test_timeout();
    test_tie_sweep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule